// File: doc/BRIEF.md
# Bi-Phase Mark Clock and Command Decoder

This block takes one serial line that carries a bit clock and a command stream in bi-phase mark form and recovers both. Every bit period starts with a line transition. A data 1 adds a second transition half a period later, and a data 0 adds nothing. With no data being sent, the line is therefore a square wave at half the bit rate. The line is sampled by a clock running at OSR times the bit rate (8 by default) after a two-flop synchroniser. Transitions are found by comparing successive samples.

While unlocked, the decoder hunts for a run of transitions spaced one bit period apart. Once locked, a phase counter is re-aligned by every leading transition. Each transition is sorted into one of three classes: leading edge, mid-period data edge, or code violation. Once per bit, the decoder reports the bit value with a one-cycle strobe. It also drives a recovered bit clock that is high for half of each period, a lock flag and a saturating count of code violations.

Top module: `bpm_decoder`

## Requirements
- R1: While reset is held and in the first cycle after release, lock_o, bit_valid_o, bit_data_o, rclk_o, code_err_o and err_count_o are all 0.
- R2: Lock asserts at the transition that completes 8 consecutive intervals, each 7, 8 or 9 samples long (OSR ±1), with no other transition between them. Any interval outside that range restarts the count. A zero-bit stream that starts from an idle line therefore locks at the leading edge of its ninth bit.
- R3: The reported bit is 1 when a transition lands 3, 4 or 5 samples after the leading edge (OSR/2 ±1). It is 0 when no transition lands in that window.
- R4: While locked, bit_valid_o pulses for exactly one cycle per bit period, a few samples after the leading edge. Each pulse reports the period that just ended. The first pulse after lock reports the period that completed acquisition, which is 0.
- R5: While locked, a transition 7, 8 or 9 samples after the previous leading edge counts as the next leading edge and re-aligns the phase. Leading edges that drift by one sample keep lock and keep the data correct.
- R6: Lock drops when the leading transition is missing in two consecutive periods. A single missing leading edge keeps lock. Strobes continue up to and including the period in which lock drops, and a period without a mid transition reports 0.
- R7: A transition while locked that lands in neither the leading window nor the mid window pulses code_err_o for one cycle and adds 1 to err_count_o, saturating at all ones. It changes neither lock nor data. Transitions while unlocked are never counted.
- R8: While locked on a steady stream, rclk_o is high for exactly OSR/2 of every OSR samples, starting at the detected leading edge. While unlocked, rclk_o is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, OSR times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | 1 | Encoded serial line, digital, asynchronous to clk |
| rclk_o | output | 1 | Recovered bit clock, high for half of each period |
| bit_data_o | output | 1 | Recovered command bit, valid with bit_valid_o |
| bit_valid_o | output | 1 | One-cycle strobe per recovered bit |
| lock_o | output | 1 | Decoder is locked to the leading edges |
| code_err_o | output | 1 | One-cycle pulse on a misplaced transition |
| err_count_o | output | ERR_W | Saturating count of misplaced transitions |

## Verification
The bench probes the acquisition boundary by placing a data 1 inside a preamble. A decoder that did not restart its interval count would lock too early, and possibly onto mid-period edges. The bench lets the leading edge drift by one sample from bit to bit. A phase counter that failed to re-align would start calling leading edges violations, or would drop lock. It injects transitions a quarter period into a bit. A decoder with overlapping or misplaced windows would either miss them or corrupt the data bit. It ends each stream abruptly, so an early unlock would lose the last bit, and a missing unlock would keep producing strobes. All-ones, all-zeros and random payloads are compared bit by bit with the strobes. On jitter-free streams, the high samples of the recovered clock are counted.

// File: rtl/bpm_pkg.sv
// Shared types for the bi-phase mark decoder.
package bpm_pkg;

    // Classification of one detected line transition while locked.
    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_LEAD = 2'd1,
        EDGE_MID  = 2'd2,
        EDGE_BAD  = 2'd3
    } edge_cls_t;

endpackage

// File: rtl/bpm_edge_sync.sv
// Two-flop synchroniser for the asynchronous encoded line, followed by a
// third flop so that a transition is detected by comparing successive
// samples. Assumes the line is already a clean digital signal.
module bpm_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic tr_o
);

    logic [2:0] smp_q;

    // Shift the line through the synchroniser and history flops.
    always_ff @(posedge clk) begin
        if (!rst_n) smp_q <= 3'b000;
        else        smp_q <= {smp_q[1:0], line_i};
    end

    // A transition is a difference between the two newest settled samples.
    assign tr_o = smp_q[1] ^ smp_q[2];

endmodule

// File: rtl/bpm_phase_track.sv
// Phase tracker. While unlocked, it measures the spacing of transitions and
// locks after LOCK_RUN consecutive one-period intervals (OSR +-1 samples).
// While locked, a phase counter counts samples since the last leading edge,
// re-aligns on every leading transition and classifies each transition.
// Lock is dropped after MISS_LIMIT consecutive periods without a leading
// edge. Assumes OSR is even and at least 8, so that the windows are disjoint.
module bpm_phase_track
    import bpm_pkg::*;
#(
    parameter int OSR        = 8,
    parameter int LOCK_RUN   = 8,
    parameter int MISS_LIMIT = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tr_i,
    output logic [$clog2(2*OSR)-1:0]    phase_o,
    output logic                        lock_o,
    output logic                        tick_o,
    output edge_cls_t                   cls_o
);

    localparam int PW = $clog2(2*OSR);
    localparam int RW = $clog2(LOCK_RUN + 1);
    localparam int MW = $clog2(MISS_LIMIT + 1);
    localparam logic [PW-1:0] PH_MAX  = PW'(2*OSR - 1);
    localparam logic [PW-1:0] PH_LAST = PW'(OSR - 1);
    localparam logic [PW-1:0] PH_ONE  = PW'(1);
    localparam logic [PW-1:0] PH_TICK = PW'(2);
    localparam logic [PW-1:0] MID_LO  = PW'(OSR/2 - 1);
    localparam logic [PW-1:0] MID_HI  = PW'(OSR/2 + 1);
    localparam logic [PW-1:0] PER_LO  = PW'(OSR - 1);
    localparam logic [PW-1:0] PER_HI  = PW'(OSR + 1);
    localparam logic [RW-1:0] RUN_END = RW'(LOCK_RUN - 1);
    localparam logic [MW-1:0] MISS_END = MW'(MISS_LIMIT - 1);

    logic [PW-1:0] ph_q;
    logic          lk_q;
    logic [RW-1:0] run_q;
    logic [MW-1:0] miss_q;
    logic          lead_seen_q;
    logic          near_lead, near_mid, near_period, tick;

    // Window decode of the current phase.
    always_comb begin
        near_lead   = (ph_q == PH_LAST) || (ph_q == '0) || (ph_q == PH_ONE);
        near_mid    = (ph_q >= MID_LO) && (ph_q <= MID_HI);
        near_period = (ph_q >= PER_LO) && (ph_q <= PER_HI);
        tick        = lk_q && (ph_q == PH_TICK);
    end

    // Classify a transition seen while locked.
    always_comb begin
        cls_o = EDGE_NONE;
        if (lk_q && tr_i) begin
            if (near_lead)     cls_o = EDGE_LEAD;
            else if (near_mid) cls_o = EDGE_MID;
            else               cls_o = EDGE_BAD;
        end
    end

    // Acquisition, phase tracking and lock-loss state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q        <= PH_MAX;
            lk_q        <= 1'b0;
            run_q       <= '0;
            miss_q      <= '0;
            lead_seen_q <= 1'b0;
        end else if (!lk_q) begin
            if (tr_i) begin
                ph_q <= PH_ONE;
                if (near_period) begin
                    if (run_q == RUN_END) begin
                        lk_q        <= 1'b1;
                        run_q       <= '0;
                        miss_q      <= '0;
                        lead_seen_q <= 1'b1;
                    end else begin
                        run_q <= run_q + 1'b1;
                    end
                end else begin
                    run_q <= '0;
                end
            end else if (ph_q != PH_MAX) begin
                ph_q <= ph_q + 1'b1;
            end
        end else begin
            if (tr_i && near_lead)  ph_q <= PH_ONE;
            else if (ph_q == PH_LAST) ph_q <= '0;
            else                    ph_q <= ph_q + 1'b1;

            if (tr_i && near_lead) lead_seen_q <= 1'b1;
            else if (tick)         lead_seen_q <= 1'b0;

            if (tick) begin
                if (lead_seen_q) begin
                    miss_q <= '0;
                end else if (miss_q == MISS_END) begin
                    lk_q   <= 1'b0;
                    miss_q <= '0;
                    run_q  <= '0;
                end else begin
                    miss_q <= miss_q + 1'b1;
                end
            end
        end
    end

    assign phase_o = ph_q;
    assign lock_o  = lk_q;
    assign tick_o  = tick;

    // R2: lock can only be gained on a detected transition.
    assert_lock_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lk_q) |-> $past(tr_i));

    // R5: while locked the phase stays inside one bit period.
    assert_phase_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_q |-> (ph_q <= PH_LAST));

    // R6: lock is only released at the bit-boundary check.
    assert_drop_at_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lk_q) |-> ($past(ph_q) == PH_TICK));

    // R6: a period with a leading edge never loses lock.
    assert_keep_with_lead_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_q && tick && lead_seen_q) |=> lk_q);

endmodule

// File: rtl/bpm_bit_slicer.sv
// Bit slicer. It remembers whether a mid-period transition was seen in the
// current bit, publishes that bit with a one-cycle strobe at each bit-boundary
// tick, and flags and counts misplaced transitions. Assumes the class and
// tick inputs come from the phase tracker.
module bpm_bit_slicer
    import bpm_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  edge_cls_t        cls_i,
    input  logic             tick_i,
    output logic             bit_data_o,
    output logic             bit_valid_o,
    output logic             code_err_o,
    output logic [ERR_W-1:0] err_count_o
);

    logic mid_seen_q;

    // Track the mid-period transition and publish the bit at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_seen_q  <= 1'b0;
            bit_data_o  <= 1'b0;
            bit_valid_o <= 1'b0;
        end else begin
            bit_valid_o <= tick_i;
            if (tick_i) begin
                bit_data_o <= mid_seen_q;
                mid_seen_q <= 1'b0;
            end else if (cls_i == EDGE_MID) begin
                mid_seen_q <= 1'b1;
            end
        end
    end

    // Flag and count misplaced transitions, saturating at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_err_o  <= 1'b0;
            err_count_o <= '0;
        end else begin
            code_err_o <= (cls_i == EDGE_BAD);
            if ((cls_i == EDGE_BAD) && (err_count_o != '1))
                err_count_o <= err_count_o + 1'b1;
        end
    end

    // R4: the strobe never lasts longer than one cycle.
    assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid_o |=> !bit_valid_o);

    // R7: each flagged violation advances the count by one or holds it at saturation.
    assert_err_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        code_err_o |-> ((err_count_o == $past(err_count_o) + 1'b1) || (&err_count_o)));

    // R7: without a flag the count does not move.
    assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !code_err_o |-> $stable(err_count_o));

endmodule

// File: rtl/bpm_decoder.sv
// Bi-phase mark clock and command decoder top level. It chains the line
// synchroniser, the phase tracker and the bit slicer, and derives the
// recovered bit clock from the tracker phase. Assumes clk runs at OSR times
// the bit rate and that line_i is a digital line.
module bpm_decoder #(
    parameter int OSR        = 8,
    parameter int LOCK_RUN   = 8,
    parameter int MISS_LIMIT = 2,
    parameter int ERR_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    output logic             rclk_o,
    output logic             bit_data_o,
    output logic             bit_valid_o,
    output logic             lock_o,
    output logic             code_err_o,
    output logic [ERR_W-1:0] err_count_o
);

    localparam int PW = $clog2(2*OSR);
    localparam logic [PW-1:0] PH_HALF = PW'(OSR/2);

    logic                 tr;
    logic [PW-1:0]        phase;
    logic                 locked;
    logic                 tick;
    bpm_pkg::edge_cls_t   cls;

    bpm_edge_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_i),
        .tr_o   (tr)
    );

    bpm_phase_track #(
        .OSR        (OSR),
        .LOCK_RUN   (LOCK_RUN),
        .MISS_LIMIT (MISS_LIMIT)
    ) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .tr_i    (tr),
        .phase_o (phase),
        .lock_o  (locked),
        .tick_o  (tick),
        .cls_o   (cls)
    );

    bpm_bit_slicer #(
        .ERR_W (ERR_W)
    ) u_slice (
        .clk         (clk),
        .rst_n       (rst_n),
        .cls_i       (cls),
        .tick_i      (tick),
        .bit_data_o  (bit_data_o),
        .bit_valid_o (bit_valid_o),
        .code_err_o  (code_err_o),
        .err_count_o (err_count_o)
    );

    // Recovered clock: high for the first half of each locked period.
    assign rclk_o = locked && (phase < PH_HALF);
    assign lock_o = locked;

    // R4: strobes come only from a locked decoder.
    assert_valid_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid_o |-> $past(locked));

    // R7: a violation is only flagged while locked.
    assert_err_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        code_err_o |-> $past(locked));

endmodule

// File: tb/bpm_decoder_bench.sv
module bpm_decoder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int OSR        = 8;
    localparam int ERR_W      = 8;
    localparam int MAXB       = 300;

    logic             clk;
    logic             rst_n;
    logic             line_r;
    logic             rclk_o, bit_data_o, bit_valid_o, lock_o, code_err_o;
    logic [ERR_W-1:0] err_count_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit bit_a [0:MAXB];
    int jit_a [0:MAXB];
    bit vio_a [0:MAXB];
    bit vdat  [0:511];

    bpm_decoder #(.OSR(OSR), .ERR_W(ERR_W)) u_bpm_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (line_r),
        .rclk_o      (rclk_o),
        .bit_data_o  (bit_data_o),
        .bit_valid_o (bit_valid_o),
        .lock_o      (lock_o),
        .code_err_o  (code_err_o),
        .err_count_o (err_count_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected count of strobes: periods from lock to the drop period.
    function automatic int exp_valids(input int n, input int lock_at);
        return n - lock_at + 2;
    endfunction

    // Expected rclk high samples over a steady locked stretch.
    function automatic int exp_rclk(input int periods);
        return periods * (OSR / 2);
    endfunction

    // Fill the stimulus arrays: 8-bit zero preamble, then the payload.
    task automatic build(input int n, input int mode, input bit jit_on, input int vrate);
        for (int b = 0; b <= MAXB; b++) begin
            bit_a[b] = 1'b0; jit_a[b] = 0; vio_a[b] = 1'b0;
        end
        for (int b = 0; b < n; b++) begin
            if (b >= 8) begin
                if (mode == 1)      bit_a[b] = 1'b1;
                else if (mode == 2) bit_a[b] = 1'($urandom % 2);
            end
            if (jit_on) jit_a[b] = int'($urandom % 2);
            if (vrate > 0 && b >= 10 && b < n - 2 && ($urandom % vrate) == 0) begin
                vio_a[b] = 1'b1;
                jit_a[b] = 0;
            end
        end
    endtask

    // Drive one stream followed by four silent periods and check it.
    task automatic session(input int n, input int lock_at, input bit rclk_chk, input string tag);
        int vcnt = 0, ecnt = 0, nviol = 0, rcnt = 0, idle_hi = 0, drops = 0, bad = 0;
        int err0 = int'(err_count_o);
        int ev;
        for (int b = 0; b < n + 4; b++) begin
            for (int s = 0; s < OSR; s++) begin
                @(negedge clk);
                if (bit_valid_o && vcnt < 512) begin vdat[vcnt] = bit_data_o; vcnt++; end
                if (code_err_o) ecnt++;
                if (rclk_chk && b >= lock_at + 2 && b < n && rclk_o) rcnt++;
                if (b >= n + 3 && (rclk_o || bit_valid_o)) idle_hi++;
                if (b > lock_at && b < n && !lock_o) drops++;
                if (b < n) begin
                    if ((s == jit_a[b]) || (bit_a[b] && s == OSR/2) || (vio_a[b] && s == 2))
                        line_r = ~line_r;
                    if (vio_a[b] && s == 2) nviol++;
                end
                if (s == 6) begin
                    if (b == lock_at - 1) chk(lock_o == 1'b0, {"R2 early lock ", tag}, int'(lock_o), 0);
                    if (b == lock_at)     chk(lock_o == 1'b1, {"R2 lock ", tag}, int'(lock_o), 1);
                    if (b == n)           chk(lock_o == 1'b1, {"R6 one miss keeps lock ", tag}, int'(lock_o), 1);
                    if (b == n + 2)       chk(lock_o == 1'b0, {"R6 two misses drop ", tag}, int'(lock_o), 0);
                end
            end
        end
        bit_a[n] = 1'b0;
        ev = exp_valids(n, lock_at);
        chk(vcnt == ev, {"R4 strobe count ", tag}, vcnt, ev);
        for (int k = 0; k < vcnt && k < ev; k++) begin
            if (vdat[k] != bit_a[lock_at - 1 + k]) begin
                bad++;
                chk(1'b0, {"R3 data bit ", tag}, int'(vdat[k]), int'(bit_a[lock_at - 1 + k]));
            end
        end
        chk(bad == 0, {"R3 payload ", tag}, bad, 0);
        chk(drops == 0, {"R5 lock held ", tag}, drops, 0);
        chk(ecnt == nviol, {"R7 violation pulses ", tag}, ecnt, nviol);
        chk(int'(err_count_o) - err0 == nviol, {"R7 violation count ", tag}, int'(err_count_o) - err0, nviol);
        chk(idle_hi == 0, {"R8 idle rclk/strobe ", tag}, idle_hi, 0);
        if (rclk_chk)
            chk(rcnt == exp_rclk(n - lock_at - 2), {"R8 rclk duty ", tag}, rcnt, exp_rclk(n - lock_at - 2));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed_r;
        seed_r = int'($urandom(32'h5EED_0BAD));
        rst_n  = 1'b0;
        line_r = 1'b0;
        repeat (4) @(negedge clk);
        // R1: outputs during reset
        chk({lock_o, bit_valid_o, rclk_o, code_err_o} == 4'b0, "R1 reset outputs", int'({lock_o, bit_valid_o, rclk_o, code_err_o}), 0);
        chk(err_count_o == '0, "R1 reset count", int'(err_count_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({lock_o, bit_valid_o, bit_data_o, rclk_o} == 4'b0, "R1 after release", int'({lock_o, bit_valid_o, bit_data_o, rclk_o}), 0);
        repeat (20) @(negedge clk);

        // All-zero payload, steady timing.
        build(24, 0, 1'b0, 0);
        session(24, 8, 1'b1, "zeros");

        // All-ones payload, steady timing.
        build(24, 1, 1'b0, 0);
        session(24, 8, 1'b1, "ones");

        // A data 1 in the preamble restarts acquisition (R2).
        build(30, 2, 1'b0, 0);
        for (int b = 0; b < 14; b++) bit_a[b] = 1'b0;
        bit_a[5] = 1'b1;
        session(30, 14, 1'b1, "restart");

        // Directed violations with a random payload (R7).
        build(40, 2, 1'b0, 0);
        vio_a[12] = 1'b1; vio_a[15] = 1'b1; vio_a[16] = 1'b1; vio_a[30] = 1'b1;
        session(40, 8, 1'b1, "viol");

        // Random payload with one-sample leading-edge drift (R5).
        build(200, 2, 1'b1, 0);
        session(200, 8, 1'b0, "jitter");

        // Random payload, drift and random violations.
        build(150, 2, 1'b1, 12);
        session(150, 8, 1'b0, "mixed");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule